// File: doc/BRIEF.md
# Break-Even Kernel Placement Controller

This block decides, one request at a time, where the next compute kernel of a host-plus-reconfigurable-fabric system should run. Each request carries a bitmap of the kernels that are ready, the kernel type of every kernel ID, four timing tables indexed by kernel type, a mode bit and a short lookahead list of the kernel types expected next. The block picks one ready kernel. It weighs the kernel's host run time against the fabric cost, which is fabric run time plus transfer time plus reconfiguration time. It then returns a verdict: host or fabric. For a fabric verdict it also returns a slot index and a flag that says whether that slot must be reconfigured.

The block keeps its own record of which kernel type is loaded in each reconfigurable slot and of the order in which the slots were loaded. It updates that record whenever it sends a kernel to the fabric. Requests enter through a valid/ready handshake. The inputs are captured on the accepting edge, and the answer is held on a second valid/ready handshake until it is taken. Loading bitstreams and moving data are left to the surrounding system.

Top module: `kernel_placer`

## Requirements
- R1: The kernel chosen is the ready kernel with the lowest ID. With an empty ready bitmap the result has `res_none_o`=1, `res_fabric_o`=0, `res_reconfig_o`=0, slot 0 and kernel 0.
- R2: With `mode_prefer_res_i`=1 the kernel chosen is the lowest-ID ready kernel whose type is loaded in a valid slot. When no such kernel exists, the choice falls back to the R1 rule.
- R3: If the chosen kernel's type is loaded in a slot, its reconfiguration time counts as zero. A fabric verdict then returns the lowest such slot with `res_reconfig_o`=0.
- R4: The verdict is host (`res_fabric_o`=0) when host time <= reconfiguration + transfer + fabric time. An exact tie goes to the host.
- R5: The overhead sum is computed on 32-bit unsigned times and saturates at 2^32-1 instead of wrapping.
- R6: `res_reconfig_o` is 1 only for a fabric verdict whose reconfiguration time in the comparison is nonzero.
- R7: A fabric verdict for a kernel that is not loaded takes the lowest-index empty slot when one exists.
- R8: With no empty slot, slots are scanned from index 0 upward. A slot is skipped when its loaded type equals an entry of the lookahead list whose valid bit is set (entry w is bits [w*TYPE_W +: TYPE_W], valid bit w). The first slot not skipped is chosen.
- R9: When every slot is skipped, the slot loaded longest ago is chosen.
- R10: A fabric verdict that needs a slot records the kernel type in that slot and marks it loaded. A host verdict leaves the slot record unchanged.
- R11: `start_ready_o` is 1 only while idle, and all request inputs are sampled on the accepting edge. The result is held stable with `res_valid_o`=1 until `res_ready_i` is 1. After reset the block is idle with all slots empty.
- R12: The result appears no more than NUM_SLOTS+3 rising edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Request present |
| start_ready_o | output | 1 | Block idle, request accepted on this edge |
| mode_prefer_res_i | input | 1 | Prefer ready kernels whose type is loaded |
| ready_map_i | input | NUM_KERNELS | Ready bit per kernel ID |
| kind_map_i | input | NUM_KERNELS*TYPE_W | Kernel type of each kernel ID |
| host_time_i | input | NUM_TYPES*TW | Host run time per type |
| fab_time_i | input | NUM_TYPES*TW | Fabric run time per type |
| rcfg_time_i | input | NUM_TYPES*TW | Reconfiguration time per type |
| comm_time_i | input | NUM_TYPES*TW | Transfer time per type |
| ahead_type_i | input | LOOK_W*TYPE_W | Upcoming kernel types |
| ahead_vld_i | input | LOOK_W | Valid bit per lookahead entry |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Result taken |
| res_none_o | output | 1 | No kernel was ready |
| res_kernel_o | output | KID_W | Chosen kernel ID |
| res_fabric_o | output | 1 | 1 = fabric, 0 = host |
| res_slot_o | output | SLOT_W | Slot for a fabric verdict |
| res_reconfig_o | output | 1 | Slot must be reconfigured |

## Verification
The bench builds the block with eight kernels and eight types, three slots and a three-entry lookahead. With three slots, every slot is full after three loads. A dozen requests then reach the empty-slot path, the scan with matches and partly valid lookahead entries, and the oldest-slot fallback, in which the load order changes after each eviction. The 32-bit times let a directed case push the overhead sum past 2^32, so saturation can be told apart from wrap-around.

// File: rtl/kp_pkg.sv
package kp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_VERD,
    ST_SCAN,
    ST_DONE
  } kp_state_e;

  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/kp_pick.sv
module kp_pick #(
  parameter int unsigned NUM_KERNELS = 8,
  parameter int unsigned NUM_SLOTS   = 3,
  parameter int unsigned TYPE_W      = 3,
  localparam int unsigned KID_W      = kp_pkg::idx_w(NUM_KERNELS),
  localparam int unsigned SLOT_W     = kp_pkg::idx_w(NUM_SLOTS)
) (
  input  logic [NUM_KERNELS-1:0]        ready_i,
  input  logic [NUM_KERNELS*TYPE_W-1:0] kind_i,
  input  logic                          prefer_i,
  input  logic [NUM_SLOTS-1:0]          slot_vld_i,
  input  logic [NUM_SLOTS*TYPE_W-1:0]   slot_type_i,
  output logic                          found_o,
  output logic [KID_W-1:0]              kid_o,
  output logic [TYPE_W-1:0]             type_o,
  output logic                          resident_o,
  output logic [SLOT_W-1:0]             res_slot_o
);

  logic [NUM_KERNELS-1:0] is_res;
  logic                   any_res;
  logic [KID_W-1:0]       kid_plain;
  logic [KID_W-1:0]       kid_res;

  always_comb begin
    for (int k = 0; k < NUM_KERNELS; k++) begin
      is_res[k] = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (slot_vld_i[s] && (slot_type_i[s*TYPE_W +: TYPE_W] == kind_i[k*TYPE_W +: TYPE_W]))
          is_res[k] = 1'b1;
      end
    end
  end

  // descending scan so the lowest index is the last one written
  always_comb begin
    found_o   = 1'b0;
    any_res   = 1'b0;
    kid_plain = '0;
    kid_res   = '0;
    for (int k = NUM_KERNELS - 1; k >= 0; k--) begin
      if (ready_i[k]) begin
        found_o   = 1'b1;
        kid_plain = KID_W'(k);
      end
      if (ready_i[k] && is_res[k]) begin
        any_res = 1'b1;
        kid_res = KID_W'(k);
      end
    end
  end

  assign kid_o      = (prefer_i && any_res) ? kid_res : kid_plain;
  assign type_o     = kind_i[int'(kid_o)*TYPE_W +: TYPE_W];
  assign resident_o = is_res[kid_o];

  always_comb begin
    res_slot_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slot_vld_i[s] && (slot_type_i[s*TYPE_W +: TYPE_W] == type_o))
        res_slot_o = SLOT_W'(s);
    end
  end

endmodule

// File: rtl/kp_verdict.sv
module kp_verdict #(
  parameter int unsigned TW = 32
) (
  input  logic [TW-1:0] host_i,
  input  logic [TW-1:0] fab_i,
  input  logic [TW-1:0] rcfg_i,
  input  logic [TW-1:0] comm_i,
  input  logic          resident_i,
  output logic          fabric_o,
  output logic          load_o
);

  logic [TW-1:0] rcfg_eff;
  logic [TW+1:0] raw_sum;
  logic [TW-1:0] ovh;

  assign rcfg_eff = resident_i ? '0 : rcfg_i;
  assign raw_sum  = {2'b00, rcfg_eff} + {2'b00, comm_i} + {2'b00, fab_i};
  // clamp instead of wrap
  assign ovh      = (|raw_sum[TW+1:TW]) ? {TW{1'b1}} : raw_sum[TW-1:0];
  // tie goes to the host
  assign fabric_o = host_i > ovh;
  assign load_o   = fabric_o && (rcfg_eff != '0);

endmodule

// File: rtl/kp_slot_table.sv
module kp_slot_table #(
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned TYPE_W    = 3,
  localparam int unsigned SLOT_W   = kp_pkg::idx_w(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_en_i,
  input  logic [SLOT_W-1:0]           load_slot_i,
  input  logic [TYPE_W-1:0]           load_type_i,
  output logic [NUM_SLOTS-1:0]        slot_vld_o,
  output logic [NUM_SLOTS*TYPE_W-1:0] slot_type_o,
  output logic                        any_free_o,
  output logic [SLOT_W-1:0]           first_free_o,
  output logic [SLOT_W-1:0]           oldest_o
);

  // age 0 = most recent load; valid slots hold distinct ages
  logic [SLOT_W-1:0] age_q [NUM_SLOTS];
  logic [SLOT_W-1:0] sel_age;
  logic              sel_vld;

  assign sel_age = age_q[load_slot_i];
  assign sel_vld = slot_vld_o[load_slot_i];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic              vld_d;
    logic [TYPE_W-1:0] type_d;
    logic [TYPE_W-1:0] type_q;
    logic [SLOT_W-1:0] age_d;

    always_comb begin
      vld_d  = slot_vld_o[s];
      type_d = type_q;
      age_d  = age_q[s];
      if (load_en_i) begin
        if (load_slot_i == SLOT_W'(s)) begin
          vld_d  = 1'b1;
          type_d = load_type_i;
          age_d  = '0;
        end else if (slot_vld_o[s] && (!sel_vld || (age_q[s] < sel_age))) begin
          age_d = age_q[s] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_vld_o[s] <= 1'b0;
        type_q        <= '0;
        age_q[s]      <= '0;
      end else if (load_en_i) begin
        slot_vld_o[s] <= vld_d;
        type_q        <= type_d;
        age_q[s]      <= age_d;
      end
    end

    assign slot_type_o[s*TYPE_W +: TYPE_W] = type_q;
  end

  always_comb begin
    any_free_o   = 1'b0;
    first_free_o = '0;
    oldest_o     = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (!slot_vld_o[s]) begin
        any_free_o   = 1'b1;
        first_free_o = SLOT_W'(s);
      end
    end
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slot_vld_o[s] && (age_q[s] >= age_q[oldest_o] || !slot_vld_o[oldest_o]))
        oldest_o = SLOT_W'(s);
    end
  end

  // R10: a load marks its slot occupied with the requested type
  a_r10_load_marks_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> slot_vld_o[$past(load_slot_i)] &&
                  (slot_type_o[int'($past(load_slot_i))*TYPE_W +: TYPE_W] == $past(load_type_i)));

  // R10: slot state only changes on a load
  a_r10_state_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> $stable(slot_vld_o) && $stable(slot_type_o));

endmodule

// File: rtl/kernel_placer.sv
module kernel_placer #(
  parameter int unsigned NUM_KERNELS = 8,
  parameter int unsigned NUM_TYPES   = 8,
  parameter int unsigned NUM_SLOTS   = 3,
  parameter int unsigned LOOK_W      = 3,
  parameter int unsigned TW          = 32,
  localparam int unsigned TYPE_W     = kp_pkg::idx_w(NUM_TYPES),
  localparam int unsigned KID_W      = kp_pkg::idx_w(NUM_KERNELS),
  localparam int unsigned SLOT_W     = kp_pkg::idx_w(NUM_SLOTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_valid_i,
  output logic                          start_ready_o,
  input  logic                          mode_prefer_res_i,
  input  logic [NUM_KERNELS-1:0]        ready_map_i,
  input  logic [NUM_KERNELS*TYPE_W-1:0] kind_map_i,
  input  logic [NUM_TYPES*TW-1:0]       host_time_i,
  input  logic [NUM_TYPES*TW-1:0]       fab_time_i,
  input  logic [NUM_TYPES*TW-1:0]       rcfg_time_i,
  input  logic [NUM_TYPES*TW-1:0]       comm_time_i,
  input  logic [LOOK_W*TYPE_W-1:0]      ahead_type_i,
  input  logic [LOOK_W-1:0]             ahead_vld_i,
  output logic                          res_valid_o,
  input  logic                          res_ready_i,
  output logic                          res_none_o,
  output logic [KID_W-1:0]              res_kernel_o,
  output logic                          res_fabric_o,
  output logic [SLOT_W-1:0]             res_slot_o,
  output logic                          res_reconfig_o
);
  import kp_pkg::*;

  localparam int unsigned CNT_W     = $clog2(NUM_SLOTS + 4);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  kp_state_e state_q, state_d;
  logic      accept;
  assign start_ready_o = (state_q == ST_IDLE);
  assign res_valid_o   = (state_q == ST_DONE);
  assign accept        = start_valid_i && start_ready_o;

  // request capture, enabled only on the accepting edge
  logic                          lat_mode_q;
  logic [NUM_KERNELS-1:0]        lat_ready_q;
  logic [NUM_KERNELS*TYPE_W-1:0] lat_kind_q;
  logic [NUM_TYPES*TW-1:0]       lat_host_q, lat_fab_q, lat_rcfg_q, lat_comm_q;
  logic [LOOK_W*TYPE_W-1:0]      lat_aty_q;
  logic [LOOK_W-1:0]             lat_avld_q;

  always_ff @(posedge clk_i) begin
    if (accept) begin
      lat_mode_q  <= mode_prefer_res_i;
      lat_ready_q <= ready_map_i;
      lat_kind_q  <= kind_map_i;
      lat_host_q  <= host_time_i;
      lat_fab_q   <= fab_time_i;
      lat_rcfg_q  <= rcfg_time_i;
      lat_comm_q  <= comm_time_i;
      lat_aty_q   <= ahead_type_i;
      lat_avld_q  <= ahead_vld_i;
    end
  end

  // slot record
  logic [NUM_SLOTS-1:0]        slot_vld;
  logic [NUM_SLOTS*TYPE_W-1:0] slot_type;
  logic                        any_free;
  logic [SLOT_W-1:0]           first_free, oldest;
  logic                        load_en;
  logic [SLOT_W-1:0]           load_slot;
  logic [TYPE_W-1:0]           p_type_q, p_type_d;

  kp_slot_table #(.NUM_SLOTS(NUM_SLOTS), .TYPE_W(TYPE_W)) i_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .load_en_i    (load_en),
    .load_slot_i  (load_slot),
    .load_type_i  (p_type_q),
    .slot_vld_o   (slot_vld),
    .slot_type_o  (slot_type),
    .any_free_o   (any_free),
    .first_free_o (first_free),
    .oldest_o     (oldest)
  );

  // kernel selection
  logic              pk_found, pk_res;
  logic [KID_W-1:0]  pk_kid;
  logic [TYPE_W-1:0] pk_type;
  logic [SLOT_W-1:0] pk_rslot;

  kp_pick #(.NUM_KERNELS(NUM_KERNELS), .NUM_SLOTS(NUM_SLOTS), .TYPE_W(TYPE_W)) i_pick (
    .ready_i     (lat_ready_q),
    .kind_i      (lat_kind_q),
    .prefer_i    (lat_mode_q),
    .slot_vld_i  (slot_vld),
    .slot_type_i (slot_type),
    .found_o     (pk_found),
    .kid_o       (pk_kid),
    .type_o      (pk_type),
    .resident_o  (pk_res),
    .res_slot_o  (pk_rslot)
  );

  logic              p_found_q, p_found_d, p_res_q, p_res_d;
  logic [KID_W-1:0]  p_kid_q, p_kid_d;
  logic [SLOT_W-1:0] p_rslot_q, p_rslot_d;

  // verdict
  logic v_fab, v_load;
  kp_verdict #(.TW(TW)) i_verdict (
    .host_i     (lat_host_q[int'(p_type_q)*TW +: TW]),
    .fab_i      (lat_fab_q[int'(p_type_q)*TW +: TW]),
    .rcfg_i     (lat_rcfg_q[int'(p_type_q)*TW +: TW]),
    .comm_i     (lat_comm_q[int'(p_type_q)*TW +: TW]),
    .resident_i (p_res_q),
    .fabric_o   (v_fab),
    .load_o     (v_load)
  );

  // lookahead match for the slot under scan
  logic [SLOT_W-1:0] scan_q, scan_d;
  logic [TYPE_W-1:0] scan_type;
  logic [LOOK_W-1:0] ahead_hit;
  assign scan_type = slot_type[int'(scan_q)*TYPE_W +: TYPE_W];

  for (genvar w = 0; w < LOOK_W; w++) begin : g_ahead
    assign ahead_hit[w] = lat_avld_q[w] && (lat_aty_q[w*TYPE_W +: TYPE_W] == scan_type);
  end

  logic              r_none_q, r_none_d, r_fab_q, r_fab_d, r_rcfg_q, r_rcfg_d;
  logic [KID_W-1:0]  r_kid_q, r_kid_d;
  logic [SLOT_W-1:0] r_slot_q, r_slot_d;
  logic [CNT_W-1:0]  busy_q, busy_d;

  always_comb begin
    state_d   = state_q;
    scan_d    = scan_q;
    busy_d    = busy_q;
    p_found_d = p_found_q;
    p_res_d   = p_res_q;
    p_kid_d   = p_kid_q;
    p_type_d  = p_type_q;
    p_rslot_d = p_rslot_q;
    r_none_d  = r_none_q;
    r_fab_d   = r_fab_q;
    r_rcfg_d  = r_rcfg_q;
    r_kid_d   = r_kid_q;
    r_slot_d  = r_slot_q;
    load_en   = 1'b0;
    load_slot = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_valid_i) begin
          state_d = ST_PICK;
          busy_d  = '0;
        end
      end
      ST_PICK: begin
        p_found_d = pk_found;
        p_res_d   = pk_res;
        p_kid_d   = pk_kid;
        p_type_d  = pk_type;
        p_rslot_d = pk_rslot;
        busy_d    = busy_q + 1'b1;
        state_d   = ST_VERD;
      end
      ST_VERD: begin
        busy_d   = busy_q + 1'b1;
        r_kid_d  = p_kid_q;
        r_none_d = !p_found_q;
        r_fab_d  = 1'b0;
        r_rcfg_d = 1'b0;
        r_slot_d = '0;
        state_d  = ST_DONE;
        if (p_found_q && v_fab) begin
          r_fab_d  = 1'b1;
          r_rcfg_d = v_load;
          if (p_res_q) begin
            r_slot_d = p_rslot_q;
          end else if (any_free) begin
            r_slot_d  = first_free;
            load_en   = 1'b1;
            load_slot = first_free;
          end else begin
            scan_d  = '0;
            state_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        busy_d = busy_q + 1'b1;
        if (!(|ahead_hit)) begin
          r_slot_d  = scan_q;
          load_en   = 1'b1;
          load_slot = scan_q;
          state_d   = ST_DONE;
        end else if (scan_q == LAST) begin
          r_slot_d  = oldest;
          load_en   = 1'b1;
          load_slot = oldest;
          state_d   = ST_DONE;
        end else begin
          scan_d = scan_q + 1'b1;
        end
      end
      ST_DONE: begin
        if (res_ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      scan_q    <= '0;
      busy_q    <= '0;
      p_found_q <= 1'b0;
      p_res_q   <= 1'b0;
      p_kid_q   <= '0;
      p_type_q  <= '0;
      p_rslot_q <= '0;
      r_none_q  <= 1'b0;
      r_fab_q   <= 1'b0;
      r_rcfg_q  <= 1'b0;
      r_kid_q   <= '0;
      r_slot_q  <= '0;
    end else begin
      state_q   <= state_d;
      scan_q    <= scan_d;
      busy_q    <= busy_d;
      p_found_q <= p_found_d;
      p_res_q   <= p_res_d;
      p_kid_q   <= p_kid_d;
      p_type_q  <= p_type_d;
      p_rslot_q <= p_rslot_d;
      r_none_q  <= r_none_d;
      r_fab_q   <= r_fab_d;
      r_rcfg_q  <= r_rcfg_d;
      r_kid_q   <= r_kid_d;
      r_slot_q  <= r_slot_d;
    end
  end

  assign res_none_o     = r_none_q;
  assign res_fabric_o   = r_fab_q;
  assign res_reconfig_o = r_rcfg_q;
  assign res_kernel_o   = r_kid_q;
  assign res_slot_o     = r_slot_q;

  // R6: reconfiguration is only requested with a fabric verdict
  a_r6_reconfig_needs_fabric: assert property (@(posedge clk_i) disable iff (!rst_n)
    (res_valid_o && res_reconfig_o) |-> res_fabric_o);

  // R1: an empty pick reports a host verdict without reconfiguration
  a_r1_none_is_host: assert property (@(posedge clk_i) disable iff (!rst_n)
    (res_valid_o && res_none_o) |-> (!res_fabric_o && !res_reconfig_o));

  // R11: result held until taken
  a_r11_result_held: assert property (@(posedge clk_i) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_kernel_o) &&
      $stable(res_fabric_o) && $stable(res_slot_o) && $stable(res_reconfig_o) &&
      $stable(res_none_o)));

  // R12: decision window bounded by the slot count
  a_r12_bounded_latency: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_DONE) |-> (busy_q <= CNT_W'(NUM_SLOTS + 1)));

  // R7: slot index within range on a fabric verdict
  a_r7_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    (res_valid_o && res_fabric_o) |-> (int'(res_slot_o) < NUM_SLOTS));

endmodule

// File: tb/test_kernel_placer.sv
module test_kernel_placer;

  localparam int NK = 8, NT = 8, NS = 3, LW = 3, TW = 32, TYW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              start_valid = 1'b0, start_ready, mode = 1'b0;
  logic [NK-1:0]     ready_map = '0;
  logic [NK*TYW-1:0] kind_map;
  logic [NT*TW-1:0]  host_t, fab_t, rcfg_t, comm_t;
  logic [LW*TYW-1:0] aty = '0;
  logic [LW-1:0]     avld = '0;
  logic              res_valid, res_ready = 1'b0, res_none, res_fab, res_rcfg;
  logic [2:0]        res_kid;
  logic [1:0]        res_slot;

  kernel_placer #(.NUM_KERNELS(NK), .NUM_TYPES(NT), .NUM_SLOTS(NS), .LOOK_W(LW), .TW(TW))
  i_kernel_placer (
    .clk_i(clk), .rst_ni(rst_n), .start_valid_i(start_valid), .start_ready_o(start_ready),
    .mode_prefer_res_i(mode), .ready_map_i(ready_map), .kind_map_i(kind_map),
    .host_time_i(host_t), .fab_time_i(fab_t), .rcfg_time_i(rcfg_t), .comm_time_i(comm_t),
    .ahead_type_i(aty), .ahead_vld_i(avld), .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_none_o(res_none), .res_kernel_o(res_kid), .res_fabric_o(res_fab),
    .res_slot_o(res_slot), .res_reconfig_o(res_rcfg)
  );

  int n_chk = 0, n_fail = 0, lat = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic set_type(input int t, input logic [31:0] h, f, r, c);
    host_t[t*TW +: TW] = h;
    fab_t[t*TW +: TW]  = f;
    rcfg_t[t*TW +: TW] = r;
    comm_t[t*TW +: TW] = c;
  endtask

  task automatic defaults();
    for (int t = 0; t < NT; t++) set_type(t, 200, 10, 50, 20);
    set_type(3, 80, 10, 50, 20);  // 80 == 50+20+10: exact tie
  endtask

  // issue one request, wait for the result, leave outputs for checking, then take it
  task automatic request(input logic [7:0] r, input logic m, input logic [8:0] a, input logic [2:0] v);
    @(negedge clk);
    ready_map = r; mode = m; aty = a; avld = v; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] rdy;
    logic       mode;
    logic [8:0] aty;   // {entry2, entry1, entry0}
    logic [2:0] avld;
    logic       none;
    logic       fab;
    logic [1:0] slot;
    logic       rcfg;
    logic [2:0] kid;
  } vec_t;

  // kernel k has type k; type 3 ties to host, all others favour the fabric
  localparam vec_t VEC [14] = '{
    '{8'h00, 1'b0, 9'o000, 3'b000, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0}, // R1 empty
    '{8'h08, 1'b0, 9'o000, 3'b000, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3}, // R4 tie -> host
    '{8'h04, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd0, 1'b1, 3'd2}, // R7, R10 slot 0 still free
    '{8'h04, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd0, 1'b0, 3'd2}, // R3 resident
    '{8'h03, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd1, 1'b1, 3'd0}, // R1 lowest, R7
    '{8'h08, 1'b0, 9'o000, 3'b000, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3}, // host
    '{8'h06, 1'b1, 9'o000, 3'b000, 1'b0, 1'b1, 2'd0, 1'b0, 3'd2}, // R2 prefer resident
    '{8'h22, 1'b1, 9'o000, 3'b000, 1'b0, 1'b1, 2'd2, 1'b1, 3'd1}, // R2 fallback, R7
    '{8'h10, 1'b0, 9'o002, 3'b011, 1'b0, 1'b1, 2'd2, 1'b1, 3'd4}, // R8 skip 0,1
    '{8'h20, 1'b0, 9'o402, 3'b111, 1'b0, 1'b1, 2'd0, 1'b1, 3'd5}, // R9 oldest = 0
    '{8'h40, 1'b0, 9'o405, 3'b110, 1'b0, 1'b1, 2'd0, 1'b1, 3'd6}, // R8 invalid entry ignored
    '{8'h80, 1'b0, 9'o406, 3'b111, 1'b0, 1'b1, 2'd1, 1'b1, 3'd7}, // R9 oldest = 1
    '{8'h18, 1'b1, 9'o000, 3'b000, 1'b0, 1'b1, 2'd2, 1'b0, 3'd4}, // R2 resident beats lower id
    '{8'h18, 1'b0, 9'o000, 3'b000, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3}  // R1, R4
  };

  task automatic check_res(input vec_t e);
    check("R1 none",         32'(res_none), 32'(e.none));
    check("R1/R2 kernel",    32'(res_kid),  32'(e.kid));
    check("R4 verdict",      32'(res_fab),  32'(e.fab));
    check("R7/R8/R9 slot",   32'(res_slot), 32'(e.slot));
    check("R6/R3 reconfig",  32'(res_rcfg), 32'(e.rcfg));
    check("R12 latency",     32'(lat <= NS + 3), 32'd1);
  endtask

  initial begin
    for (int k = 0; k < NK; k++) kind_map[k*TYW +: TYW] = TYW'(k);
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset ready", 32'(start_ready), 32'd1);
    check("R11 reset valid", 32'(res_valid), 32'd0);

    foreach (VEC[i]) begin
      request(VEC[i].rdy, VEC[i].mode, VEC[i].aty, VEC[i].avld);
      check_res(VEC[i]);
      take();
    end
    // slots now: 0 -> type 6, 1 -> type 7, 2 -> type 4

    // R5: wrapped sum would be 0xB8 < host and pick fabric; saturated sum keeps host
    set_type(5, 32'hFFFF_FFFF, 32'd100, 32'hFFFF_FFF0, 32'd100);
    request(8'h20, 1'b0, 9'o000, 3'b000);
    check_res('{8'h20, 1'b0, 9'o000, 3'b000, 1'b0, 1'b0, 2'd0, 1'b0, 3'd5});
    take();

    // R3: type 4 is loaded, 1000 reconfiguration is ignored: 30 < 100 -> fabric
    set_type(4, 100, 10, 1000, 20);
    request(8'h10, 1'b0, 9'o000, 3'b000);
    check_res('{8'h10, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd2, 1'b0, 3'd4});
    take();

    // R6: zero reconfiguration time on a load gives no reconfigure flag; R8 takes slot 0
    set_type(0, 200, 10, 0, 20);
    request(8'h01, 1'b0, 9'o000, 3'b000);
    check_res('{8'h01, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0});
    take();

    // R11: inputs changed after acceptance have no effect; result held while not taken
    defaults();
    @(negedge clk);
    ready_map = 8'h01; mode = 1'b0; avld = '0; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    ready_map = 8'h80;
    set_type(0, 1, 10, 50, 20);
    check("R11 busy not ready", 32'(start_ready), 32'd0);
    lat = 1;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    repeat (3) @(negedge clk);
    check_res('{8'h01, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0});
    check("R11 held valid", 32'(res_valid), 32'd1);
    take();
    check("R11 idle again", 32'(start_ready), 32'd1);

    // R11/R7: reset empties the slot record
    defaults();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset valid", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset ready", 32'(start_ready), 32'd1);
    request(8'h04, 1'b0, 9'o000, 3'b000);
    check_res('{8'h04, 1'b0, 9'o000, 3'b000, 1'b0, 1'b1, 2'd0, 1'b1, 3'd2});
    take();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule